// File: doc/BRIEF.md
# External Bus Hold Arbiter

This block hands a shared external memory bus to an outside master through an active-low request and grant handshake. The request pin may change at any time, so it passes through a synchronizer before the sequencer sees it. Once a request is seen, the block tells the local memory controller to start nothing new. It waits for any transfer already under way to finish, including long stretched asynchronous accesses or forced SDRAM bursts, and then turns off the whole bus output group. Only after the bus has floated for a fixed time does it pull the grant low. When the request goes away, the grant rises first and the bus is driven again one cycle later.

A defer bit lets software keep the bus local. While the bit is 1, a waiting request is never granted. The sequencer walks through five named states. OWNED is the local side driving the bus. DRAIN waits for the controller to go idle. FLOAT_WAIT holds the bus floated before the grant. GRANTED is the outside master owning the bus. RELEASE hands the bus back.

The transitions are these. OWNED goes to DRAIN on a synchronized request with the defer bit at 0. DRAIN goes back to OWNED if the request is withdrawn or the defer bit is set. DRAIN goes to FLOAT_WAIT once its minimum time has run and the controller is idle. FLOAT_WAIT goes to GRANTED after its fixed count. GRANTED goes to RELEASE when the synchronized request drops. RELEASE goes to OWNED after its fixed count.

Top module: `bus_hold_arbiter`

## Requirements
All cycle counts below use the same reference edge, called edge 1. Edge 1 is the first rising clock edge at which `ext_req_n` has its new level. Inputs are stable around edges.
- R1: After reset, `ext_gnt_n` is 1, `bus_drive_en` is 1 and `mc_stall` is 0.
- R2: With `mc_busy` low and `defer_grant` 0, a request (`ext_req_n` falling) has these effects. `mc_stall` rises after edge 3. `bus_drive_en` falls after edge 5 and not earlier.
- R3: `ext_gnt_n` falls exactly 2 cycles after `bus_drive_en` falls.
- R4: `bus_drive_en` stays 1 while `mc_busy` is 1. With busy, the bus floats after the later of edge 5 and the first edge that samples `mc_busy` low.
- R5: `mc_stall` is 1 in every state except OWNED. It rises before the bus floats. It falls only together with `bus_drive_en` returning to 1.
- R6: From GRANTED, when `ext_req_n` rises, `ext_gnt_n` rises after edge 5. `bus_drive_en` rises after edge 6.
- R7: `ext_gnt_n` is never 0 while `bus_drive_en` is 1.
- R8: While `defer_grant` is 1, a request has no effect. The grant stays 1, the bus stays driven and `mc_stall` stays 0. When the bit clears with the request still low, the grant follows. The bus floats 3 edges after the clearing edge and the grant falls 5 edges after it.
- R9: In DRAIN, withdrawing the request or setting `defer_grant` sends the block back to OWNED with no grant. A withdrawal is seen through the synchronizer. `defer_grant` acts at the first edge that samples it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_req_n | input | 1 | Asynchronous bus request from the outside master, active low |
| mc_busy | input | 1 | Memory controller has a transfer in progress |
| defer_grant | input | 1 | Configuration bit; 1 withholds the grant |
| ext_gnt_n | output | 1 | Bus grant to the outside master, active low |
| bus_drive_en | output | 1 | Output enable for the whole external bus group |
| mc_stall | output | 1 | Tells the memory controller to start no new transfer |

## Verification
Two things can fall on the same edge: the end of the minimum drain time and the controller going idle. The random trials hold `mc_busy` high for 0 to 9 cycles after the request. This places the busy drop before, on and after the edge where the minimum time expires. The bench computes the float edge as the later of the two and checks every cycle's outputs against it. A second collision is a request withdrawal or defer-bit set arriving while the drain is still waiting on a busy controller. Directed cases check that the block returns to OWNED on the predicted edge and never issues a grant.

// File: rtl/bus_hold_pkg.sv
package bus_hold_pkg;

    typedef enum logic [2:0] {
        ST_OWNED      = 3'd0,
        ST_DRAIN      = 3'd1,
        ST_FLOAT_WAIT = 3'd2,
        ST_GRANTED    = 3'd3,
        ST_RELEASE    = 3'd4
    } hold_state_t;

endpackage

// File: rtl/req_synchronizer.sv
module req_synchronizer #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);

    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '1;
                else        chain <= async_in;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '1;
                else        chain <= {chain[STAGES-2:0], async_in};
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/phase_timer.sv
module phase_timer #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             done
);

    logic [CNT_W-1:0] count;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)              count <= '0;
        else if (load)           count <= load_val;
        else if (count != '0)    count <= count - 1'b1;
    end

    assign done = (count == '0);

endmodule

// File: rtl/hold_sequencer.sv
module hold_sequencer
    import bus_hold_pkg::*;
#(
    parameter int DRAIN_MIN = 2,
    parameter int FLOAT_CYC = 2,
    parameter int GNT_LAG   = 2,
    parameter int CNT_W     = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req,
    input  logic             mc_busy,
    input  logic             defer_grant,
    input  logic             timer_done,
    output logic             timer_load,
    output logic [CNT_W-1:0] timer_val,
    output logic             ext_gnt_n,
    output logic             bus_drive_en,
    output logic             mc_stall
);

    localparam logic [CNT_W-1:0] DRAIN_LOAD = CNT_W'(DRAIN_MIN - 1);
    localparam logic [CNT_W-1:0] FLOAT_LOAD = CNT_W'(FLOAT_CYC - 1);
    localparam logic [CNT_W-1:0] REL_LOAD   = CNT_W'(GNT_LAG);

    hold_state_t state, state_nx;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_OWNED;
        else        state <= state_nx;
    end

    // next state and timer loading
    always_comb begin
        state_nx   = state;
        timer_load = 1'b0;
        timer_val  = '0;
        unique case (state)
            ST_OWNED: begin
                if (req && !defer_grant) begin
                    state_nx   = ST_DRAIN;
                    timer_load = 1'b1;
                    timer_val  = DRAIN_LOAD;
                end
            end
            ST_DRAIN: begin
                if (!req || defer_grant) begin
                    state_nx = ST_OWNED;
                end else if (timer_done && !mc_busy) begin
                    state_nx   = ST_FLOAT_WAIT;
                    timer_load = 1'b1;
                    timer_val  = FLOAT_LOAD;
                end
            end
            ST_FLOAT_WAIT: begin
                if (timer_done) state_nx = ST_GRANTED;
            end
            ST_GRANTED: begin
                if (!req) begin
                    state_nx   = ST_RELEASE;
                    timer_load = 1'b1;
                    timer_val  = REL_LOAD;
                end
            end
            ST_RELEASE: begin
                if (timer_done) state_nx = ST_OWNED;
            end
        endcase
    end

    // outputs
    always_comb begin
        ext_gnt_n    = 1'b1;
        bus_drive_en = 1'b1;
        mc_stall     = 1'b1;
        unique case (state)
            ST_OWNED:      mc_stall = 1'b0;
            ST_DRAIN:      ;
            ST_FLOAT_WAIT: bus_drive_en = 1'b0;
            ST_GRANTED: begin
                bus_drive_en = 1'b0;
                ext_gnt_n    = 1'b0;
            end
            ST_RELEASE: begin
                bus_drive_en = 1'b0;
                ext_gnt_n    = timer_done;
            end
        endcase
    end

    // R7: grant only while the bus is floated
    assert_gnt_needs_float_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !ext_gnt_n |-> !bus_drive_en);

    // R3: the bus was already floated in the cycle before the grant fell
    assert_float_precedes_grant_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ext_gnt_n) |-> $past(!bus_drive_en));

    // R5: whenever the bus floats the controller is stalled
    assert_stall_covers_float_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_drive_en |-> mc_stall);

    // R4: a busy controller keeps the drain from ending
    assert_busy_blocks_float_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRAIN && mc_busy) |=> bus_drive_en);

    // R8: the defer bit keeps the bus local
    assert_defer_keeps_bus_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_OWNED && defer_grant) |=> (state == ST_OWNED));

    // R9: a withdrawn request in drain returns to local ownership
    assert_abort_returns_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DRAIN && !req) |=> (state == ST_OWNED));

endmodule

// File: rtl/bus_hold_arbiter.sv
module bus_hold_arbiter #(
    parameter int SYNC_STAGES = 2,
    parameter int DRAIN_MIN   = 2,
    parameter int FLOAT_CYC   = 2,
    parameter int GNT_LAG     = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_req_n,
    input  logic mc_busy,
    input  logic defer_grant,
    output logic ext_gnt_n,
    output logic bus_drive_en,
    output logic mc_stall
);

    localparam int MAX_A  = (DRAIN_MIN > FLOAT_CYC) ? DRAIN_MIN : FLOAT_CYC;
    localparam int MAX_CNT = (MAX_A > GNT_LAG) ? MAX_A : GNT_LAG;
    localparam int CNT_W  = (MAX_CNT < 2) ? 1 : $clog2(MAX_CNT + 1);

    logic             req_n_sync;
    logic             req;
    logic             t_load;
    logic [CNT_W-1:0] t_val;
    logic             t_done;

    req_synchronizer #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (ext_req_n),
        .sync_out (req_n_sync)
    );

    assign req = ~req_n_sync;

    phase_timer #(.CNT_W(CNT_W)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (t_load),
        .load_val (t_val),
        .done     (t_done)
    );

    hold_sequencer #(
        .DRAIN_MIN (DRAIN_MIN),
        .FLOAT_CYC (FLOAT_CYC),
        .GNT_LAG   (GNT_LAG),
        .CNT_W     (CNT_W)
    ) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .req          (req),
        .mc_busy      (mc_busy),
        .defer_grant  (defer_grant),
        .timer_done   (t_done),
        .timer_load   (t_load),
        .timer_val    (t_val),
        .ext_gnt_n    (ext_gnt_n),
        .bus_drive_en (bus_drive_en),
        .mc_stall     (mc_stall)
    );

endmodule

// File: tb/tb_bus_hold_arbiter.sv
module tb_bus_hold_arbiter;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ext_req_n = 1'b1;
    logic mc_busy = 1'b0;
    logic defer_grant = 1'b0;
    logic ext_gnt_n, bus_drive_en, mc_stall;

    int vectors = 0;
    int miscompares = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    bus_hold_arbiter dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .ext_req_n    (ext_req_n),
        .mc_busy      (mc_busy),
        .defer_grant  (defer_grant),
        .ext_gnt_n    (ext_gnt_n),
        .bus_drive_en (bus_drive_en),
        .mc_stall     (mc_stall)
    );

    task automatic check(input string req, input string what, input logic act, input logic exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s %s at %0t: actual %b expected %b", req, what, $time, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic check_all(input string req, input logic g, input logic oe, input logic st);
        check(req, "ext_gnt_n", ext_gnt_n, g);
        check(req, "bus_drive_en", bus_drive_en, oe);
        check(req, "mc_stall", mc_stall, st);
        check("R7", "grant with bus driven", (!ext_gnt_n && bus_drive_en), 1'b0);
    endtask

    // expected float edge: later of minimum drain and first idle sample
    function automatic int exp_float(input int busy_ticks);
        return (busy_ticks + 1 > 5) ? busy_ticks + 1 : 5;
    endfunction

    function automatic logic exp_oe_grant(input int i, input int f);
        return (i < f);
    endfunction

    function automatic logic exp_gnt_grant(input int i, input int f);
        return (i < f + 2);
    endfunction

    // release from GRANTED; returns with the block in OWNED
    task automatic do_release(input string req);
        ext_req_n = 1'b0;
        ext_req_n = 1'b1;
        for (int i = 1; i <= 6; i++) begin
            tick();
            check_all(req, (i >= 5), (i >= 6), (i < 6));
        end
        tick();
        tick();
    endtask

    // one grant with busy held for busy_ticks, granted for gl ticks
    task automatic grant_cycle(input int busy_ticks, input int gl, input string req);
        int f;
        f = exp_float(busy_ticks);
        ext_req_n = 1'b0;
        mc_busy   = (busy_ticks > 0);
        for (int i = 1; i <= f + 2 + gl; i++) begin
            tick();
            check_all(req, exp_gnt_grant(i, f), exp_oe_grant(i, f), (i >= 3));
            if (i == busy_ticks) mc_busy = 1'b0;
        end
        do_release("R6");
    endtask

    initial begin
        void'($urandom(32'h1d5e_a11c));
        tick();
        check_all("R1", 1'b1, 1'b1, 1'b0);
        tick();
        rst_n = 1'b1;
        tick();
        check_all("R1", 1'b1, 1'b1, 1'b0);

        // R2 and R3: idle controller, minimum timing
        grant_cycle(0, 3, "R2");
        // R4: busy outlasts the minimum, and busy ending on the minimum edge
        grant_cycle(8, 2, "R4");
        grant_cycle(4, 2, "R4");
        // R3 directed: grant exactly two cycles after float
        grant_cycle(1, 1, "R3");

        // R8: defer bit holds the bus local
        defer_grant = 1'b1;
        ext_req_n   = 1'b0;
        for (int i = 1; i <= 20; i++) begin
            tick();
            check_all("R8", 1'b1, 1'b1, 1'b0);
        end
        defer_grant = 1'b0;
        for (int i = 1; i <= 7; i++) begin
            tick();
            check_all("R8", (i < 5), (i < 3), 1'b1);
        end
        do_release("R6");

        // R9: withdrawal during drain
        ext_req_n = 1'b0;
        mc_busy   = 1'b1;
        for (int i = 1; i <= 3; i++) begin
            tick();
            check_all("R9", 1'b1, 1'b1, (i >= 3));
        end
        ext_req_n = 1'b1;
        for (int i = 4; i <= 9; i++) begin
            tick();
            check_all("R9", 1'b1, 1'b1, (i < 6));
        end
        mc_busy = 1'b0;
        tick();

        // R9: defer bit set during drain
        ext_req_n = 1'b0;
        mc_busy   = 1'b1;
        for (int i = 1; i <= 3; i++) begin
            tick();
            check_all("R9", 1'b1, 1'b1, (i >= 3));
        end
        defer_grant = 1'b1;
        for (int i = 4; i <= 8; i++) begin
            tick();
            check_all("R9", 1'b1, 1'b1, (i < 4));
        end
        ext_req_n   = 1'b1;
        mc_busy     = 1'b0;
        defer_grant = 1'b0;
        tick();
        tick();
        tick();
        check_all("R5", 1'b1, 1'b1, 1'b0);

        // random trials: busy length and grant length from the seed
        for (int t = 0; t < 40; t++) begin
            grant_cycle(int'($urandom_range(0, 9)), int'($urandom_range(1, 8)), "R4");
        end

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            miscompares++;
            $display("FAIL watchdog: actual running expected done");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
            $finish;
        end
    end

endmodule